// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Register Slave

This block is a register-file slave that sits on an 8-bit bus where the same lines carry an address first and data afterwards. An active-high address strobe marks the address phase; the block holds the bus value while the strobe is high and adopts it as the current address when the strobe falls. The strobe does not need chip select. Reads and writes that follow use this address. Each read or write needs chip select active for the whole of its active-low strobe. Write data is taken as the strobe ends. During a read the block drives the addressed contents while the read strobe is low and releases the bus afterwards.

All strobes and the bus are sampled into the system clock domain. Behind the bus sits a 128-location array. A few locations at the bottom of the array are fixed identification bytes that cannot be written. Addresses above the array are not implemented. A power-fail input blocks every read and write while it is high. The pad is split into an input, an output and an output enable. Pad drivers are outside the block.

Top module: `adbus_slave`

## Requirements
- R1: After reset the output enable is low, the output bus is 00h, and every writable location reads 00h.
- R2: The latched address is the last bus value seen while the address strobe was high. It takes effect when the strobe falls.
- R3: An address strobe pulse with chip select inactive still updates the latched address. A write strobe with chip select inactive changes nothing.
- R4: A write strobe with chip select active for its whole low period stores the bus value present just before the strobe rises. The value goes into the latched address, and exactly one commit happens per pulse.
- R5: If chip select goes inactive at any time during a write strobe, that pulse writes nothing, even if chip select returns before the strobe ends.
- R6: While chip select is active and the read strobe is low, the output enable is high and the output bus carries the contents of the latched address. Once the read strobe is high again, the output enable is low and the output bus is 00h.
- R7: A read strobe with chip select inactive never raises the output enable.
- R8: While power-fail is high, the output enable stays low and write pulses store nothing.
- R9: Locations 00h to 03h are read-only and read C0h ORed with their address (00h reads C0h, 02h reads C2h). Writes to them are ignored.
- R10: Addresses 80h to FFh read 00h with the output enable high. Writes to them are ignored and do not reach the location that has the same low 7 address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busIn | input | 8 | Value on the shared address/data lines |
| busOut | output | 8 | Read data toward the pad, 00h when not driving |
| busOe | output | 1 | Pad output enable, high while driving read data |
| aleIn | input | 1 | Address strobe, active high |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| powerFail | input | 1 | Supply-fail indication, high blocks all access |

## Verification
The bench changes the bus just before the address strobe falls. A design that latched early, or on the rising edge, would read back the wrong location. It latches an address with chip select inactive, then reads with no new address phase, which shows that the address was taken while the attempted write was dropped. It drops chip select briefly inside a write pulse and writes above the array with a low-bit alias already holding data. A design that checked chip select only at the strobe edges, or that decoded only 7 address bits, would corrupt a stored byte. Power-fail, reads without chip select and writes to the fixed identification bytes are each followed by a read at the pins, so that a blocked access that leaked through shows up as a changed value or a driven bus.

// File: rtl/adbus_pkg.sv
package adbus_pkg;
  localparam int BUS_W = 8;

  // control -> datapath strobes
  typedef struct packed {
    logic             aleAct;
    logic             csAct;
    logic             rdAct;
    logic             wrAct;
    logic             rdEn;
    logic             wrCommit;
    logic [BUS_W-1:0] wrAddr;
    logic [BUS_W-1:0] wrData;
    logic [BUS_W-1:0] rdAddr;
  } strobe_t;

  function automatic logic [BUS_W-1:0] roValue(input int idx);
    logic [BUS_W-1:0] v;
    v = BUS_W'(idx);
    return v | BUS_W'(8'hC0);
  endfunction
endpackage

// File: rtl/adbus_sync.sv
module adbus_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RESET_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/adbus_ctrl.sv
module adbus_ctrl
  import adbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] busIn,
  input  logic             aleIn,
  input  logic             csN,
  input  logic             rdN,
  input  logic             wrN,
  input  logic             powerFail,
  output strobe_t          strb
);
  logic [3:0]       ctlRaw;
  logic [3:0]       ctlSync;
  logic [BUS_W-1:0] busSync;
  logic aleS, csS, rdS, wrS;
  logic aleD, wrD;
  logic [BUS_W-1:0] addrHold, addrLatched, dataHold;
  logic [BUS_W-1:0] commitAddr, commitData;
  logic wrGood, commit;
  logic aleFall, wrStart, wrEnd;

  assign ctlRaw = {aleIn, ~csN, ~rdN, ~wrN};

  adbus_sync #(.W(4), .STAGES(SYNC_STAGES), .RESET_VAL(4'b0000)) ctlSync_i (
    .clk(clk), .rst_n(rst_n), .d(ctlRaw), .q(ctlSync)
  );

  adbus_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) busSync_i (
    .clk(clk), .rst_n(rst_n), .d(busIn), .q(busSync)
  );

  assign {aleS, csS, rdS, wrS} = ctlSync;
  assign aleFall = aleD && !aleS;
  assign wrStart = wrS && !wrD;
  assign wrEnd   = !wrS && wrD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aleD        <= 1'b0;
      wrD         <= 1'b0;
      addrHold    <= '0;
      addrLatched <= '0;
      dataHold    <= '0;
      wrGood      <= 1'b0;
      commit      <= 1'b0;
      commitAddr  <= '0;
      commitData  <= '0;
    end else begin
      aleD <= aleS;
      wrD  <= wrS;
      if (aleS) addrHold <= busSync;
      if (aleFall) addrLatched <= addrHold;
      if (wrS) dataHold <= busSync;
      if (wrStart) wrGood <= csS && !powerFail;
      else if (wrS && (!csS || powerFail)) wrGood <= 1'b0;
      else if (wrEnd) wrGood <= 1'b0;
      commit     <= wrEnd && wrGood && csS && !powerFail;
      commitAddr <= addrLatched;
      commitData <= dataHold;
    end
  end

  always_comb begin
    strb.aleAct   = aleS;
    strb.csAct    = csS;
    strb.rdAct    = rdS;
    strb.wrAct    = wrS;
    strb.rdEn     = csS && rdS && !powerFail;
    strb.wrCommit = commit;
    strb.wrAddr   = commitAddr;
    strb.wrData   = commitData;
    strb.rdAddr   = addrLatched;
  end
endmodule

// File: rtl/adbus_dp.sv
module adbus_dp
  import adbus_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int RO_COUNT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strb,
  output logic [BUS_W-1:0] rdData
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic [BUS_W-1:0] cellQ [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    if (i < RO_COUNT) begin : g_ro
      assign cellQ[i] = roValue(i);
    end else begin : g_rw
      logic [BUS_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (strb.wrCommit && (int'(strb.wrAddr) == i)) q <= strb.wrData;
      end
      assign cellQ[i] = q;
    end
  end

  always_comb begin
    if (int'(strb.rdAddr) < DEPTH) rdData = cellQ[strb.rdAddr[ADDR_W-1:0]];
    else rdData = '0;
  end
endmodule

// File: rtl/adbus_slave.sv
module adbus_slave
  import adbus_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int RO_COUNT = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] busIn,
  output logic [BUS_W-1:0] busOut,
  output logic             busOe,
  input  logic             aleIn,
  input  logic             csN,
  input  logic             rdN,
  input  logic             wrN,
  input  logic             powerFail
);
  strobe_t          strb;
  logic [BUS_W-1:0] rdData;

  adbus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .busIn(busIn), .aleIn(aleIn), .csN(csN),
    .rdN(rdN), .wrN(wrN), .powerFail(powerFail), .strb(strb)
  );

  adbus_dp #(.DEPTH(DEPTH), .RO_COUNT(RO_COUNT)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .rdData(rdData)
  );

  assign busOe  = strb.rdEn;
  assign busOut = busOe ? rdData : '0;
endmodule

// File: rtl/adbus_checker.sv
module adbus_checker
  import adbus_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    busOe,
  input logic    powerFail,
  input strobe_t strb
);
  p_no_oe_in_pf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    powerFail |-> !busOe);

  p_oe_needs_cs_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busOe |-> (strb.csAct && strb.rdAct));

  p_addr_on_ale_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(strb.rdAddr) |-> (!$past(strb.aleAct) && $past(strb.aleAct, 2)));

  p_commit_after_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrCommit |-> (!$past(strb.wrAct) && $past(strb.wrAct, 2)));

  p_commit_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrCommit |=> !strb.wrCommit);

  p_commit_needs_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrCommit |-> $past(strb.csAct));
endmodule

bind adbus_slave adbus_checker chk_i (
  .clk(clk), .rst_n(rst_n), .busOe(busOe), .powerFail(powerFail), .strb(strb)
);

// File: tb/adbus_slave_tb.sv
module adbus_slave_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] busIn = 8'h00;
  logic [7:0] busOut;
  logic       busOe;
  logic       aleIn = 1'b0;
  logic       csN = 1'b1;
  logic       rdN = 1'b1;
  logic       wrN = 1'b1;
  logic       powerFail = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adbus_slave dut_i (
    .clk(clk), .rst_n(rst_n), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .aleIn(aleIn), .csN(csN), .rdN(rdN), .wrN(wrN), .powerFail(powerFail)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // address phase; chip select untouched
  task automatic aleCycle(input logic [7:0] addr);
    busIn = addr; aleIn = 1'b1; idle(3);
    aleIn = 1'b0; idle(3);
  endtask

  // mode 0: cs whole pulse, 1: cs drops mid pulse, 2: cs never active
  task automatic wrPulse(input logic [7:0] data, input int mode);
    if (mode != 2) csN = 1'b0;
    busIn = data; idle(2);
    wrN = 1'b0; idle(4);
    if (mode == 1) begin csN = 1'b1; idle(2); csN = 1'b0; idle(2); end
    wrN = 1'b1; idle(4);
    csN = 1'b1; busIn = 8'h00; idle(2);
  endtask

  task automatic rdPulse(input logic useCs, output logic [7:0] val,
                         output logic oe, output logic oeAfter, output logic [7:0] valAfter);
    if (useCs) csN = 1'b0;
    idle(1);
    rdN = 1'b0; idle(4);
    val = busOut; oe = busOe;
    rdN = 1'b1; idle(4);
    oeAfter = busOe; valAfter = busOut;
    csN = 1'b1; idle(2);
  endtask

  task automatic readAt(input logic [7:0] addr, input logic [7:0] exp, input string tag);
    logic [7:0] v, va; logic oe, oa;
    aleCycle(addr);
    rdPulse(1'b1, v, oe, oa, va);
    check({tag, " oe"}, {7'b0, oe}, 8'h01);
    check({tag, " data"}, v, exp);
  endtask

  task automatic t_reset();
    check("R1 reset oe", {7'b0, busOe}, 8'h00);
    check("R1 reset bus", busOut, 8'h00);
    readAt(8'h10, 8'h00, "R1 reset cell 10h");
    readAt(8'h7F, 8'h00, "R1 reset cell 7Fh");
  endtask

  task automatic t_write_read();
    logic [7:0] v, va; logic oe, oa;
    aleCycle(8'h10); wrPulse(8'hA5, 0);
    aleCycle(8'h7F); wrPulse(8'h3C, 0);
    aleCycle(8'h10);
    rdPulse(1'b1, v, oe, oa, va);
    check("R4 write 10h", v, 8'hA5);
    check("R6 oe during read", {7'b0, oe}, 8'h01);
    check("R6 oe after read", {7'b0, oa}, 8'h00);
    check("R6 bus after read", va, 8'h00);
    readAt(8'h7F, 8'h3C, "R4 write top cell 7Fh");
  endtask

  task automatic t_ale_last_value();
    logic [7:0] v, va; logic oe, oa;
    busIn = 8'h11; aleIn = 1'b1; idle(3);
    busIn = 8'h7F; idle(1);
    aleIn = 1'b0; busIn = 8'h10; idle(3);
    rdPulse(1'b1, v, oe, oa, va);
    check("R2 last value before ALE fall", v, 8'h3C);
  endtask

  task automatic t_ale_without_cs();
    logic [7:0] v, va; logic oe, oa;
    aleCycle(8'h10);
    aleCycle(8'h7F);
    wrPulse(8'h99, 2);
    rdPulse(1'b1, v, oe, oa, va);
    check("R3 addr latched without cs, write dropped", v, 8'h3C);
  endtask

  task automatic t_cs_drop();
    aleCycle(8'h10); wrPulse(8'h00, 1);
    readAt(8'h10, 8'hA5, "R5 cs drop mid pulse");
  endtask

  task automatic t_read_no_cs();
    logic [7:0] v, va; logic oe, oa;
    aleCycle(8'h10);
    rdPulse(1'b0, v, oe, oa, va);
    check("R7 no oe without cs", {7'b0, oe}, 8'h00);
    check("R7 bus quiet without cs", v, 8'h00);
  endtask

  task automatic t_power_fail();
    logic [7:0] v, va; logic oe, oa;
    powerFail = 1'b1;
    aleCycle(8'h20); wrPulse(8'h55, 0);
    rdPulse(1'b1, v, oe, oa, va);
    check("R8 no oe in power fail", {7'b0, oe}, 8'h00);
    powerFail = 1'b0; idle(2);
    readAt(8'h20, 8'h00, "R8 write blocked in power fail");
  endtask

  task automatic t_read_only();
    readAt(8'h00, 8'hC0, "R9 id 00h");
    readAt(8'h03, 8'hC3, "R9 id 03h");
    aleCycle(8'h02); wrPulse(8'hFF, 0);
    readAt(8'h02, 8'hC2, "R9 id 02h write ignored");
    aleCycle(8'h04); wrPulse(8'h6E, 0);
    readAt(8'h04, 8'h6E, "R9 first writable 04h");
  endtask

  task automatic t_unimplemented();
    aleCycle(8'h05); wrPulse(8'h12, 0);
    aleCycle(8'h85); wrPulse(8'h77, 0);
    readAt(8'h85, 8'h00, "R10 read 85h");
    readAt(8'h05, 8'h12, "R10 no alias into 05h");
    readAt(8'hFF, 8'h00, "R10 read FFh");
    readAt(8'h80, 8'h00, "R10 read 80h");
  endtask

  initial begin
    fork
      begin
        idle(5);
        rst_n = 1'b1;
        idle(3);
        t_reset();
        t_write_read();
        t_ale_last_value();
        t_ale_without_cs();
        t_cs_drop();
        t_read_no_cs();
        t_power_fail();
        t_read_only();
        t_unimplemented();
        done = 1'b1;
      end
      begin
        repeat (50000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual hung expected done");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule